// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is a master for a single-wire, open-drain serial bus at standard speed. It produces every time slot on the shared line itself: the reset pulse with its presence window, the write-one slot, the write-zero slot and the read slot. The timing comes from a one-microsecond tick that a clock-divider parameter derives from the system clock. The block never drives the line high. It asserts `busPullLow`, which the pad turns into an active-low pull, and an external pull-up returns the line high. The line is read back through `busIn`, which passes through a two-stage synchroniser before it is sampled.

A command is presented on `cmdValid` and `cmdOp`. The block accepts it only while idle. It then raises `busy` and pulses `done` for one cycle when the last slot has finished. Four commands are supported: a bus reset with presence detection, a byte write, a byte read, and an identity read. The identity read runs a complete read-serial-number transaction on its own. It resets the bus and sends command 0x33, then reads eight bytes. The first byte (the family code) is thrown away, the next six form the 48-bit serial number, and the last byte (the check byte) is left readable but is not verified.

Top module: `onewire_master`

## Requirements
- R1: After reset, busy, done, busPullLow, presence, rdData and serialId are all 0.
- R2: cmdOp 2'b00 runs a reset slot. busPullLow is high for exactly 480 µs (480·CLK_PER_US cycles), then low, and the slot lasts 960 µs in total.
- R3: presence is set to 1 when busIn is low 550 µs after the start of a reset slot, and to 0 when it is high.
- R4: A write slot lasts 70 µs. A bit of value 1 holds busPullLow high for 6 µs, and a bit of value 0 holds it high for 60 µs.
- R5: cmdOp 2'b10 runs eight read slots. Each holds busPullLow high for 6 µs, samples busIn 15 µs after the slot start and lasts 70 µs. The sampled bits fill rdData least significant bit first.
- R6: cmdOp 2'b01 writes cmdData, least significant bit first, as eight write slots.
- R7: cmdOp 2'b11 runs one reset slot, writes 0x33 and then reads eight bytes. The first byte is discarded. Bytes two to seven land in serialId, with the earliest of them in bits 7:0. The eighth byte remains in rdData, and presence reflects the reset slot.
- R8: When no device answers the reset, the identity sequence still runs to completion and reports presence 0.
- R9: cmdValid is ignored while busy is high. The running command's bus waveform and its results are unchanged, and the results hold steady while the block is idle.
- R10: Every slot is preceded by one cycle with the line released. done is high for exactly one cycle, one cycle after the last slot ends. busy is high from the cycle after acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdOp | input | 2 | 00 reset, 01 write byte, 10 read byte, 11 identity read |
| cmdData | input | 8 | Byte for the write command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | 1 when a device answered the last reset slot |
| rdData | output | 8 | Last byte read from the bus |
| serialId | output | 8·ID_BYTES | Serial number captured by the identity read |
| busIn | input | 1 | Sensed bus line level |
| busPullLow | output | 1 | Pull-down enable for the open-drain line |

## Verification
The hardest situation to reach from the ports is a read slot that returns 0. That needs a device that pulls the line low in step with the master's own slot, and keeps it low past the synchroniser delay. The bench therefore models the device as part of its cycle-exact slot timeline. It holds the line low across a window that is wide on both sides of the sampling instant, both for presence pulses and for zero bits, so that both results can be reached through busIn alone. The identity read is run once with a device that answers and once on an empty bus, which shows that the sequence completes without a presence pulse.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_IDENT = 2'b11
  } owOp_e;

  typedef enum logic [1:0] {
    SLOT_RST,
    SLOT_W1,
    SLOT_W0,
    SLOT_RD
  } slotKind_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startRst;
    logic startWr;
    logic startRd;
    logic loadTx;
    logic loadCmd;
    logic shiftTx;
    logic clrId;
    logic capId;
  } owStrobe_t;

  localparam int US_W = 10;
  localparam logic [7:0] ID_CMD = 8'h33;

  localparam logic [US_W-1:0] RST_LOW_US    = US_W'(480);
  localparam logic [US_W-1:0] RST_SAMPLE_US = US_W'(550);
  localparam logic [US_W-1:0] RST_TOTAL_US  = US_W'(960);
  localparam logic [US_W-1:0] ONE_LOW_US    = US_W'(6);
  localparam logic [US_W-1:0] ZERO_LOW_US   = US_W'(60);
  localparam logic [US_W-1:0] RD_LOW_US     = US_W'(6);
  localparam logic [US_W-1:0] RD_SAMPLE_US  = US_W'(15);
  localparam logic [US_W-1:0] BIT_TOTAL_US  = US_W'(70);

  function automatic logic [US_W-1:0] slotLow(slotKind_e k);
    case (k)
      SLOT_RST: slotLow = RST_LOW_US;
      SLOT_W1:  slotLow = ONE_LOW_US;
      SLOT_W0:  slotLow = ZERO_LOW_US;
      default:  slotLow = RD_LOW_US;
    endcase
  endfunction

  function automatic logic [US_W-1:0] slotTotal(slotKind_e k);
    slotTotal = (k == SLOT_RST) ? RST_TOTAL_US : BIT_TOTAL_US;
  endfunction

  function automatic logic [US_W-1:0] slotSample(slotKind_e k);
    slotSample = (k == SLOT_RST) ? RST_SAMPLE_US : RD_SAMPLE_US;
  endfunction

endpackage

// File: rtl/ow_tick.sv
module ow_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = $clog2(DIV + 1);

  logic [DIV_W-1:0] divCnt;

  assign tick = run && (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               divCnt <= '0;
    else if (clear || !run)   divCnt <= '0;
    else if (tick)            divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/ow_datapath.sv
module ow_datapath
  import ow_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int ID_BYTES   = 6,
  localparam int ID_W      = 8 * ID_BYTES,
  localparam int PTR_W     = $clog2(ID_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  owStrobe_t       strobe,
  input  logic [7:0]      txData,
  input  logic            busIn,
  output logic            busPullLow,
  output logic            slotDone,
  output logic            presence,
  output logic [7:0]      rxByte,
  output logic [ID_W-1:0] serialId
);
  logic [1:0]      busSync;
  logic            active;
  slotKind_e       kind;
  logic [US_W-1:0] usCnt;
  logic [US_W-1:0] usNext;
  logic [7:0]      txShift;
  logic [PTR_W-1:0] idPtr;
  logic            tick;
  logic            startAny;
  logic            atSample;
  slotKind_e       nextKind;

  assign startAny = strobe.startRst | strobe.startWr | strobe.startRd;

  ow_tick #(.DIV(CLK_PER_US)) uTick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (startAny),
    .run   (active),
    .tick  (tick)
  );

  always_comb begin
    if (strobe.startRst)     nextKind = SLOT_RST;
    else if (strobe.startRd) nextKind = SLOT_RD;
    else if (txShift[0])     nextKind = SLOT_W1;
    else                     nextKind = SLOT_W0;
  end

  assign usNext     = usCnt + 1'b1;
  assign slotDone   = active && tick && (usNext == slotTotal(kind));
  assign atSample   = active && tick && (usNext == slotSample(kind)) &&
                      (kind == SLOT_RST || kind == SLOT_RD);
  assign busPullLow = active && (usCnt < slotLow(kind));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busSync <= 2'b11;
    else        busSync <= {busSync[0], busIn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind   <= SLOT_RST;
      usCnt  <= '0;
    end else if (startAny) begin
      active <= 1'b1;
      kind   <= nextKind;
      usCnt  <= '0;
    end else if (active && tick) begin
      usCnt <= usNext;
      if (slotDone) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                txShift <= '0;
    else if (strobe.loadTx)    txShift <= txData;
    else if (strobe.loadCmd)   txShift <= ID_CMD;
    else if (strobe.shiftTx)   txShift <= {1'b0, txShift[7:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte   <= '0;
      presence <= 1'b0;
    end else if (atSample) begin
      if (kind == SLOT_RD) rxByte   <= {busSync[1], rxByte[7:1]};
      else                 presence <= ~busSync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serialId <= '0;
      idPtr    <= '0;
    end else if (strobe.clrId) begin
      serialId <= '0;
      idPtr    <= '0;
    end else if (strobe.capId) begin
      serialId[int'(idPtr)*8 +: 8] <= rxByte;
      idPtr <= idPtr + 1'b1;
    end
  end
endmodule

// File: rtl/ow_control.sv
module ow_control
  import ow_pkg::*;
#(
  parameter int ID_BYTES = 6,
  localparam int BYTE_W  = $clog2(ID_BYTES + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       slotDone,
  output owStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_KICK, S_WAIT, S_FIN} state_e;
  typedef enum logic [1:0] {PH_RST, PH_WR, PH_RD} phase_e;

  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(ID_BYTES + 1);

  state_e            state;
  phase_e            phase;
  owOp_e             opReg;
  logic [2:0]        bitIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic              lastBit;
  logic              isIdent;

  assign lastBit = (bitIdx == 3'd7);
  assign isIdent = (opReg == OP_IDENT);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);

  always_comb begin
    strobe = '0;
    case (state)
      S_IDLE: if (cmdValid) begin
        strobe.loadTx = (owOp_e'(cmdOp) == OP_WRITE);
        strobe.clrId  = (owOp_e'(cmdOp) == OP_IDENT);
      end
      S_KICK: begin
        strobe.startRst = (phase == PH_RST);
        strobe.startWr  = (phase == PH_WR);
        strobe.startRd  = (phase == PH_RD);
      end
      S_WAIT: if (slotDone) begin
        strobe.shiftTx = (phase == PH_WR);
        strobe.loadCmd = (phase == PH_RST) && isIdent;
        strobe.capId   = (phase == PH_RD) && lastBit && isIdent &&
                         (byteIdx != '0) && (byteIdx != LAST_BYTE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= PH_RST;
      opReg   <= OP_RESET;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          opReg   <= owOp_e'(cmdOp);
          bitIdx  <= '0;
          byteIdx <= '0;
          case (owOp_e'(cmdOp))
            OP_WRITE: phase <= PH_WR;
            OP_READ:  phase <= PH_RD;
            default:  phase <= PH_RST;
          endcase
          state <= S_KICK;
        end
        S_KICK: state <= S_WAIT;
        S_WAIT: if (slotDone) begin
          state <= S_KICK;
          case (phase)
            PH_RST: begin
              if (isIdent) begin
                phase  <= PH_WR;
                bitIdx <= '0;
              end else begin
                state <= S_FIN;
              end
            end
            PH_WR: begin
              if (!lastBit) begin
                bitIdx <= bitIdx + 1'b1;
              end else if (isIdent) begin
                phase   <= PH_RD;
                bitIdx  <= '0;
                byteIdx <= '0;
              end else begin
                state <= S_FIN;
              end
            end
            default: begin
              if (!lastBit) begin
                bitIdx <= bitIdx + 1'b1;
              end else if (isIdent && byteIdx != LAST_BYTE) begin
                byteIdx <= byteIdx + 1'b1;
                bitIdx  <= '0;
              end else begin
                state <= S_FIN;
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int ID_BYTES   = 6,
  localparam int ID_W      = 8 * ID_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [7:0]      cmdData,
  output logic            busy,
  output logic            done,
  output logic            presence,
  output logic [7:0]      rdData,
  output logic [ID_W-1:0] serialId,
  input  logic            busIn,
  output logic            busPullLow
);
  owStrobe_t strobe;
  logic      slotDone;

  ow_control #(.ID_BYTES(ID_BYTES)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .slotDone (slotDone),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  ow_datapath #(.CLK_PER_US(CLK_PER_US), .ID_BYTES(ID_BYTES)) uPath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .txData     (cmdData),
    .busIn      (busIn),
    .busPullLow (busPullLow),
    .slotDone   (slotDone),
    .presence   (presence),
    .rxByte     (rdData),
    .serialId   (serialId)
  );
endmodule

// File: rtl/ow_checker.sv
module ow_checker #(
  parameter int CLK_PER_US = 50,
  parameter int ID_W       = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmdValid,
  input logic            busy,
  input logic            done,
  input logic            busPullLow,
  input logic            presence,
  input logic [7:0]      rdData,
  input logic [ID_W-1:0] serialId
);
  localparam logic [31:0] MAX_LOW = 32'(480 * CLK_PER_US);

  logic [31:0] lowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lowRun <= '0;
    else if (busPullLow) lowRun <= lowRun + 1'b1;
    else                 lowRun <= '0;
  end

  AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busPullLow |-> (lowRun < MAX_LOW)); // R2

  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busPullLow |-> busy); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmdValid) |=> ($stable(serialId) && $stable(rdData) && $stable(presence))); // R9
endmodule

bind onewire_master ow_checker #(.CLK_PER_US(CLK_PER_US), .ID_W(ID_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmdValid   (cmdValid),
  .busy       (busy),
  .done       (done),
  .busPullLow (busPullLow),
  .presence   (presence),
  .rdData     (rdData),
  .serialId   (serialId)
);

// File: tb/sim_onewire_master.sv
`timescale 1ns/1ps
module sim_onewire_master;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [7:0]  cmdData = 8'h00;
  logic        busy, done, presence, busPullLow, busIn;
  logic [7:0]  rdData;
  logic [47:0] serialId;
  logic        devLow = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bit   qLow[$];
  bit   qDev[$];
  logic [7:0] devBytes [0:7];
  logic        expPresence = 1'b0;
  logic [7:0]  expRd = 8'h00;
  logic [47:0] expId = 48'h0;
  int errLow, errBusy, errDone;

  assign busIn = !(busPullLow || devLow);

  always #5 clk = ~clk;

  onewire_master #(.CLK_PER_US(N), .ID_BYTES(6)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .done(done), .presence(presence),
    .rdData(rdData), .serialId(serialId), .busIn(busIn),
    .busPullLow(busPullLow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // one slot of the reference timeline: a released cycle, then the slot body
  task automatic addSlot(input int lowUs, input int totUs, input int devFrom, input int devTo);
    qLow.push_back(1'b0);
    qDev.push_back(1'b0);
    for (int c = 0; c < totUs * N; c++) begin
      qLow.push_back(c < lowUs * N);
      qDev.push_back((c >= devFrom * N) && (c < devTo * N));
    end
  endtask

  task automatic addWrite(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (b[i]) addSlot(6, 70, -1, -1);
      else      addSlot(60, 70, -1, -1);
    end
  endtask

  task automatic addRead(input logic [7:0] b, input bit here);
    for (int i = 0; i < 8; i++) begin
      if (here && !b[i]) addSlot(6, 70, 0, 40);
      else               addSlot(6, 70, -1, -1);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [7:0] wdata,
                       input bit here, input bit hold, input string tag);
    int idx;
    errLow = 0; errBusy = 0; errDone = 0;
    if (op == 2'b00 || op == 2'b11)
      addSlot(480, 960, here ? 500 : -1, here ? 700 : -1);
    if (op == 2'b01) addWrite(wdata);
    if (op == 2'b11) addWrite(8'h33);
    if (op == 2'b10) addRead(devBytes[0], here);
    if (op == 2'b11) for (int k = 0; k < 8; k++) addRead(devBytes[k], here);

    if (op == 2'b00 || op == 2'b11) expPresence = here;
    if (op == 2'b10) expRd = here ? devBytes[0] : 8'hFF;
    if (op == 2'b11) begin
      for (int k = 0; k < 6; k++) expId[k*8 +: 8] = here ? devBytes[k+1] : 8'hFF;
      expRd = here ? devBytes[7] : 8'hFF;
    end

    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = wdata;
    @(negedge clk);
    if (hold) begin cmdOp = 2'b10; cmdData = 8'h00; end
    else cmdValid = 1'b0;
    idx = 0;
    while (qLow.size() > 0) begin
      bit eL;
      eL = qLow.pop_front();
      devLow = qDev.pop_front();
      if (busPullLow !== eL) errLow++;
      if (busy !== 1'b1) errBusy++;
      if (done !== 1'b0) errDone++;
      if (hold && idx == 40) cmdValid = 1'b0;
      idx++;
      @(negedge clk);
    end
    devLow = 1'b0;
    if (done !== 1'b1 || busy !== 1'b1) errDone++;
    @(negedge clk);
    if (done !== 1'b0 || busy !== 1'b0) errBusy++;
    check({tag, " waveform"}, 64'(errLow), 64'd0);
    check("R10 busy/done timing", 64'(errBusy + errDone), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 busPullLow", 64'(busPullLow), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 presence", 64'(presence), 64'd0);
    check("R1 rdData", 64'(rdData), 64'd0);
    check("R1 serialId", 64'(serialId), 64'd0);

    // reset slot, device answers / bus empty
    doCmd(2'b00, 8'h00, 1'b1, 1'b0, "R2");
    check("R3 presence seen", 64'(presence), 64'(expPresence));
    doCmd(2'b00, 8'h00, 1'b0, 1'b0, "R2");
    check("R3 presence absent", 64'(presence), 64'(expPresence));

    // byte writes, LSB first
    doCmd(2'b01, 8'hA5, 1'b1, 1'b0, "R4 R6");
    doCmd(2'b01, 8'h0E, 1'b1, 1'b1, "R9 R6");
    check("R9 rdData untouched", 64'(rdData), 64'(expRd));
    check("R9 presence untouched", 64'(presence), 64'(expPresence));

    // byte reads
    devBytes[0] = 8'h96;
    doCmd(2'b10, 8'h00, 1'b1, 1'b0, "R5");
    check("R5 rdData 96", 64'(rdData), 64'(expRd));
    devBytes[0] = 8'h71;
    doCmd(2'b10, 8'h00, 1'b1, 1'b0, "R5");
    check("R5 rdData 71", 64'(rdData), 64'(expRd));

    // identity read with a device present
    devBytes[0] = 8'h01; devBytes[1] = 8'h3A; devBytes[2] = 8'hC5;
    devBytes[3] = 8'h10; devBytes[4] = 8'hE7; devBytes[5] = 8'h5B;
    devBytes[6] = 8'h82; devBytes[7] = 8'hD4;
    doCmd(2'b11, 8'h00, 1'b1, 1'b0, "R7");
    check("R7 serialId", 64'(serialId), 64'(expId));
    check("R7 check byte", 64'(rdData), 64'(expRd));
    check("R7 presence", 64'(presence), 64'(expPresence));

    // identity read on an empty bus
    doCmd(2'b11, 8'h00, 1'b0, 1'b0, "R8");
    check("R8 presence", 64'(presence), 64'(expPresence));
    check("R8 serialId", 64'(serialId), 64'(expId));

    repeat (3) @(negedge clk);
    check("R9 idle results stable", 64'(serialId), 64'(expId));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule